// File: doc/BRIEF.md
# Ripple-Through Cell FIFO

This block is a small first-in first-out buffer built from a chain of one-word cells rather than a memory with read and write pointers. Every cell carries its own valid flag. A word written at the input end moves by itself toward the output end. On each clock, every occupied cell whose downstream neighbour is empty hands its word over. All such moves happen in parallel. Stored words therefore pack against the output, and free cells drift back toward the input.

The producer and the consumer each use a level strobe with a ready flag. A writer waits for `inReady`, puts a word on `dataIn` and raises `shiftIn`. The word is taken on the rising edge of the strobe, and `inReady` drops. A reader waits for `outReady`, takes `dataOut` and raises `shiftOut`. This retires the word, and `outReady` drops. The next word is only advanced into the output cell once `shiftOut` is low again. When the buffer runs dry, `dataOut` keeps the last word it showed.

Everything runs on one clock. A synchronous active-low reset empties the chain.

Top module: `ripple_fifo`

## Requirements
- R1: While `rstN` is low at a clock edge, the block empties. After that edge `inReady` is 1, `outReady` is 0 and `dataOut` is 0.
- R2: A word is captured when `shiftIn` rises while `inReady` is 1. On that edge `dataIn` is stored in the input cell, and `inReady` is 0 from the next cycle.
- R3: The captured word stays in the input cell while `shiftIn` stays high, and `inReady` stays 0. On an empty buffer, `outReady` therefore stays 0 however long the strobe is held.
- R4: Once `shiftIn` is low, `inReady` returns to 1 if any cell is free. With DEPTH words stored, it stays 0. A `shiftIn` rise while `inReady` is 0 stores nothing, so exactly DEPTH words come out afterwards.
- R5: A word written into an empty buffer has `outReady` at 1 no more than DEPTH clocks after its capture edge.
- R6: Words leave in the order they were captured, with no loss or duplication, under any mix of write and read timing.
- R7: A rise of `shiftOut` while `outReady` is 1 retires the output word. `outReady` is 0 from the next cycle. `dataOut` does not change while `shiftOut` is high.
- R8: After `shiftOut` goes low, if another word is stored it moves into the output cell, and `outReady` returns to 1 with that word on `dataOut`.
- R9: While `outReady` is 0, `dataOut` keeps its value until a new word reaches the output cell. When the buffer is drained, it keeps the last word read.
- R10: A rise of `shiftOut` while `outReady` is 0 has no effect. No word is lost, and `outReady` stays 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | WIDTH | Word offered to the input cell |
| shiftIn | input | 1 | Write strobe; its rising edge captures `dataIn` |
| inReady | output | 1 | High when the input cell is free |
| shiftOut | input | 1 | Read strobe; its rising edge retires the output word |
| outReady | output | 1 | High when the output cell holds a valid word |
| dataOut | output | WIDTH | Output cell contents, held when empty |

## Verification
The bound checker covers several local strobe rules on every cycle:
- the ready flags falling after an accepted strobe,
- the input cell staying occupied while the write strobe is held,
- `dataOut` staying stable while the read strobe is high or the output is empty,
- a read strobe on an empty output being ignored.

Other behaviour only shows up across whole scenarios, so the scoreboard bench covers it:
- the fill-to-depth limit and the rejected extra write,
- the latency through an empty chain,
- word order under overlapping random writer and reader timing,
- clearing by reset in the middle of traffic.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;

  // Strobes from the handshake control to the cell chain.
  typedef struct packed {
    logic capture;   // load dataIn into the input cell
    logic headHold;  // input cell may not pass its word on
    logic pop;       // retire the word in the output cell
    logic tailHold;  // output cell may not be reloaded
  } fifoCtrl_t;

endpackage

// File: rtl/ripple_fifo_ctrl.sv
module ripple_fifo_ctrl
  import ripple_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      shiftIn,
  input  logic      shiftOut,
  input  logic      headValid,
  input  logic      tailValid,
  output fifoCtrl_t ctrl
);

  logic siPrev;
  logic soPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      siPrev <= 1'b0;
      soPrev <= 1'b0;
    end else begin
      siPrev <= shiftIn;
      soPrev <= shiftOut;
    end
  end

  logic siRise;
  logic soRise;

  always_comb begin
    siRise = shiftIn & ~siPrev;
    soRise = shiftOut & ~soPrev;

    // A write is accepted only on a strobe edge with the input cell free.
    ctrl.capture  = siRise & ~headValid;

    // While the write strobe is high, the input cell keeps its word.
    ctrl.headHold = shiftIn;

    // A read is accepted only on a strobe edge with a valid output word.
    ctrl.pop      = soRise & tailValid;

    // While the read strobe is high, the output cell is not refilled.
    ctrl.tailHold = shiftOut;
  end

endmodule

// File: rtl/ripple_cell.sv
module ripple_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             take,
  input  logic [WIDTH-1:0] takeData,
  input  logic             give,
  output logic             cellValid,
  output logic [WIDTH-1:0] cellData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellValid <= 1'b0;
      cellData  <= '0;
    end else begin
      if (take) begin
        cellValid <= 1'b1;
        cellData  <= takeData;
      end else if (give) begin
        // The word is not cleared, so an emptied output cell keeps showing it.
        cellValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ripple_fifo_path.sv
module ripple_fifo_path
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtrl_t        ctrl,
  input  logic [WIDTH-1:0] dataIn,
  output logic             headValid,
  output logic             tailValid,
  output logic [WIDTH-1:0] dataOut
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] cellValid;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] give;
  logic [WIDTH-1:0] cellData [DEPTH];
  logic [WIDTH-1:0] takeData [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    // Source side of each cell: the input cell is loaded from the port,
    // every other cell is loaded from its upstream neighbour.
    if (i == 0) begin : g_head
      assign take[i]     = ctrl.capture;
      assign takeData[i] = dataIn;
    end else begin : g_link
      logic upBlocked;
      logic hereBlocked;
      assign upBlocked   = (i == 1)    ? ctrl.headHold : 1'b0;
      assign hereBlocked = (i == LAST) ? ctrl.tailHold : 1'b0;
      assign take[i]     = cellValid[i-1] & ~cellValid[i] & ~upBlocked & ~hereBlocked;
      assign takeData[i] = cellData[i-1];
    end

    // Sink side: a cell empties when its downstream neighbour takes the
    // word, and the output cell empties when a read is accepted.
    if (i == LAST) begin : g_tail
      assign give[i] = ctrl.pop;
    end else begin : g_pass
      assign give[i] = take[i+1];
    end

    ripple_cell #(.WIDTH(WIDTH)) u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .take     (take[i]),
      .takeData (takeData[i]),
      .give     (give[i]),
      .cellValid(cellValid[i]),
      .cellData (cellData[i])
    );
  end

  assign headValid = cellValid[0];
  assign tailValid = cellValid[LAST];
  assign dataOut   = cellData[LAST];

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             shiftIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  output logic [WIDTH-1:0] dataOut
);

  fifoCtrl_t ctrl;
  logic      headValid;
  logic      tailValid;

  ripple_fifo_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .headValid(headValid),
    .tailValid(tailValid),
    .ctrl     (ctrl)
  );

  ripple_fifo_path #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dataIn   (dataIn),
    .headValid(headValid),
    .tailValid(tailValid),
    .dataOut  (dataOut)
  );

  assign inReady  = ~headValid;
  assign outReady = tailValid;

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             shiftIn,
  input logic             inReady,
  input logic             shiftOut,
  input logic             outReady,
  input logic [WIDTH-1:0] dataOut
);

  // R2
  capture_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftIn) && inReady) |=> !inReady);

  // R3
  held_strobe_keeps_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftIn && !inReady) |=> !inReady);

  // R7
  read_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftOut) && outReady) |=> !outReady);

  // R7
  read_hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftOut |=> $stable(dataOut));

  // R9
  empty_output_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |=> ($stable(dataOut) || outReady));

  // R10
  idle_read_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftOut) && !outReady) |=> !outReady);

endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .shiftIn (shiftIn),
  .inReady (inReady),
  .shiftOut(shiftOut),
  .outReady(outReady),
  .dataOut (dataOut)
);

// File: tb/ripple_fifo_tb.sv
module ripple_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;
  localparam int DEPTH      = 16;
  localparam int TIMEOUT    = 8 * DEPTH;

  logic             clk = 1'b0;
  logic             rstN;
  logic [WIDTH-1:0] dataIn;
  logic             shiftIn;
  logic             inReady;
  logic             shiftOut;
  logic             outReady;
  logic [WIDTH-1:0] dataOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ripple_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .shiftIn (shiftIn),
    .inReady (inReady),
    .shiftOut(shiftOut),
    .outReady(outReady),
    .dataOut (dataOut)
  );

  int               checks = 0;
  int               errors = 0;
  logic [WIDTH-1:0] expQ[$];
  logic [WIDTH-1:0] lastRead = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Driver: wait for room, strobe one word in, and queue it as expected.
  task automatic pushWord(logic [WIDTH-1:0] w, int gap = 0);
    int t = 0;
    while (!inReady && t < TIMEOUT) begin
      tick();
      t++;
    end
    check("R4 inReady before write", inReady, 1);
    dataIn  = w;
    shiftIn = 1'b1;
    tick();
    check("R2 inReady low after capture", inReady, 0);
    expQ.push_back(w);
    shiftIn = 1'b0;
    tick(1 + gap);
  endtask

  // Monitor: wait for a word, compare it with the queue head, then read it.
  task automatic popWord(int hold = 0);
    int               t = 0;
    logic [WIDTH-1:0] seen;
    while (!outReady && t < TIMEOUT) begin
      tick();
      t++;
    end
    check("R8 outReady for stored word", outReady, 1);
    if (expQ.size() == 0) begin
      check("R6 unexpected word", 1, 0);
    end else begin
      check("R6 word order", dataOut, expQ.pop_front());
    end
    seen     = dataOut;
    lastRead = seen;
    shiftOut = 1'b1;
    tick();
    check("R7 outReady low after read", outReady, 0);
    check("R7 dataOut held on read", dataOut, seen);
    for (int h = 0; h < hold; h++) begin
      tick();
      check("R7 dataOut stable while shiftOut high", dataOut, seen);
      check("R7 outReady low while shiftOut high", outReady, 0);
    end
    shiftOut = 1'b0;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    rstN     = 1'b0;
    dataIn   = '0;
    shiftIn  = 1'b0;
    shiftOut = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 inReady after reset", inReady, 1);
    check("R1 outReady after reset", outReady, 0);
    check("R1 dataOut after reset", dataOut, 0);
    rstN = 1'b1;
    tick();

    // R5 latency through an empty chain
    dataIn  = 4'h5;
    shiftIn = 1'b1;
    tick();
    shiftIn = 1'b0;
    expQ.push_back(4'h5);
    cnt = 0;
    while (!outReady && cnt < DEPTH + 4) begin
      tick();
      cnt++;
    end
    check("R5 first word within DEPTH clocks", (cnt <= DEPTH), 1);
    popWord(2);
    // R9 drained output keeps last word
    tick(DEPTH);
    check("R9 outReady low when empty", outReady, 0);
    check("R9 dataOut keeps last word", dataOut, 4'h5);

    // R3 held write strobe keeps the word in the input cell
    dataIn  = 4'h9;
    shiftIn = 1'b1;
    tick(DEPTH + 3);
    check("R3 outReady low while shiftIn held", outReady, 0);
    check("R3 inReady low while shiftIn held", inReady, 0);
    shiftIn = 1'b0;
    expQ.push_back(4'h9);
    tick();
    popWord(0);

    // R10 read strobe on an empty output is ignored
    shiftOut = 1'b1;
    tick(3);
    shiftOut = 1'b0;
    tick();
    check("R10 outReady after idle read", outReady, 0);
    check("R10 dataOut after idle read", dataOut, 4'h9);
    pushWord(4'hA);
    popWord(1);

    // R4 fill to depth, extra write ignored
    for (int k = 0; k < DEPTH; k++) pushWord(4'((k * 7 + 3) % 16));
    tick(2 * DEPTH);
    check("R4 inReady low when full", inReady, 0);
    dataIn  = 4'hF;
    shiftIn = 1'b1;
    tick();
    shiftIn = 1'b0;
    tick(DEPTH);
    check("R4 inReady still low after rejected write", inReady, 0);
    for (int k = 0; k < DEPTH; k++) popWord(0);
    tick(2 * DEPTH);
    check("R4 no extra word after full drain", outReady, 0);
    check("R9 dataOut keeps last word after drain", dataOut, lastRead);

    // R8 held reads with words waiting upstream
    pushWord(4'h1);
    pushWord(4'h2);
    pushWord(4'h3);
    tick(DEPTH);
    popWord(5);
    popWord(5);
    popWord(5);

    // R6 overlapping random traffic
    fork
      begin
        for (int k = 0; k < 40; k++) pushWord(4'((k * 5 + 1) % 16), int'($urandom_range(0, 3)));
      end
      begin
        for (int k = 0; k < 40; k++) begin
          tick(int'($urandom_range(0, 4)));
          popWord(int'($urandom_range(0, 2)));
        end
      end
    join
    check("R6 queue empty after stream", expQ.size(), 0);

    // R1 reset in the middle of traffic
    pushWord(4'h6);
    pushWord(4'h7);
    tick(3);
    rstN = 1'b0;
    tick();
    check("R1 inReady after mid reset", inReady, 1);
    check("R1 outReady after mid reset", outReady, 0);
    check("R1 dataOut after mid reset", dataOut, 0);
    rstN = 1'b1;
    expQ.delete();
    tick(DEPTH + 2);
    check("R1 chain stays empty after reset", outReady, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule